// File: doc/BRIEF.md
# Calibrating Seconds Prescaler

This block turns an oscillator-rate clock enable (nominally 32768 per second) into a one-per-second tick. It can also trim the long-term rate digitally. The divider is split into a low stage of 2^LO_BITS enables, the divide-by-256 stage at default sizes, and a high stage counting low-stage wraps. A trim value has a five-bit magnitude and a direction bit. Within each 64-minute correction cycle it picks minutes to carry one altered second each. In a fast trim, that second loses one full low-stage period. In a slow trim, it gains half a low-stage period.

The block tracks its own second-of-minute and minute-of-cycle positions and reports them with a pulse at each second, minute and cycle boundary. It also raises a flag while the second being counted is a corrected one. The trim inputs are sampled only at the cycle boundary, so a full cycle always runs under one setting. Reset clears the divider and both position counters, and it sets the trim in force to zero.

Top module: `calib_prescaler`

## Requirements
- R1: While reset is low, sec_pos and min_pos read 0 and sec_tick, corr_now read 0. The cycle that starts at reset release runs with no correction, whatever cal_mag holds.
- R2: An uncorrected second lasts exactly 2^(LO_BITS+HI_BITS) enabled input cycles (32768 at default sizes).
- R3: A corrected second with cal_fast=1 lasts 2^LO_BITS fewer enabled cycles than nominal (256 fewer at default sizes).
- R4: A corrected second with cal_fast=0 lasts 2^(LO_BITS-1) more enabled cycles than nominal (128 more at default sizes).
- R5: With a magnitude N in force, exactly the seconds with sec_pos=0 in minutes 0 to 2N-1 of the cycle are corrected. A magnitude of 0 corrects nothing, and every cycle then totals MIN_PER_CYC*SEC_PER_MIN nominal seconds.
- R6: With N=31, minutes 0 to 61 are corrected and minutes 62 and 63 are never corrected.
- R7: cal_mag and cal_fast are captured only at the tick that ends minute MIN_PER_CYC-1. A change made mid-cycle leaves that cycle's lengths unchanged.
- R8: Only cycles with tick_en=1 advance the divider. sec_tick is only ever high together with tick_en, and with tick_en held low the positions do not move.
- R9: sec_pos counts 0 to SEC_PER_MIN-1 and min_pos counts 0 to MIN_PER_CYC-1, each advancing with sec_tick. min_tick marks the tick of the last second of a minute, and cyc_tick marks that tick in the last minute of the cycle.
- R10: corr_now is 1 exactly while the second being counted is a corrected one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Oscillator-rate count enable |
| cal_mag | input | CAL_BITS | Trim magnitude, 0 disables correction |
| cal_fast | input | 1 | Trim direction: 1 shortens seconds, 0 lengthens them |
| sec_tick | output | 1 | One-cycle pulse ending each second |
| min_tick | output | 1 | sec_tick of the last second of a minute |
| cyc_tick | output | 1 | sec_tick of the last second of the correction cycle |
| sec_pos | output | $clog2(SEC_PER_MIN) | Second within the minute |
| min_pos | output | $clog2(MIN_PER_CYC) | Minute within the correction cycle |
| corr_now | output | 1 | Current second is a corrected one |

## Verification
The bench measures every second in enabled cycles and sets the length against a model of the window rule. A wrong edge on the minute window (N versus 2N, or < versus <=) would show up as one mis-sized second at minute 2N-1 or 2N. An off-by-one in either correction path would give 25 or 23 instead of 24, or 35 or 37 instead of 36, at the bench's reduced sizes. Magnitude 31 is driven in both directions to confirm that minutes 62 and 63 stay nominal. Trim values are changed in the middle of a cycle, so a design that sampled them at once would produce a cycle with the wrong total. Gapped and held-off enables catch a divider that counts raw clocks, and a mid-cycle reset checks that the trim in force falls back to zero.

// File: rtl/calib_pkg.sv
package calib_pkg;

  typedef enum logic {
    TRIM_SLOW = 1'b0,
    TRIM_FAST = 1'b1
  } trim_dir_e;

  // Minute selected for correction when it lies below twice the magnitude.
  function automatic logic minute_in_window(input int mag, input int minute);
    return (mag != 0) && (minute < 2 * mag);
  endfunction

  // Enabled input cycles in one second for the given trim outcome.
  function automatic int second_length(input int lo_bits, input int hi_bits,
                                       input logic corrected, input logic fast);
    int nom;
    nom = 1 << (lo_bits + hi_bits);
    if (!corrected) return nom;
    if (fast) return nom - (1 << lo_bits);
    return nom + (1 << (lo_bits - 1));
  endfunction

endpackage

// File: rtl/calib_divider.sv
module calib_divider #(
  parameter int LO_BITS = 8,
  parameter int HI_BITS = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic shorten_req,
  input  logic stretch_req,
  output logic sec_tick
);
  localparam logic [LO_BITS-1:0] LO_TOP  = '1;
  localparam logic [LO_BITS-1:0] LO_HALF = LO_BITS'((1 << (LO_BITS - 1)) - 1);
  localparam logic [HI_BITS-1:0] HI_TOP  = '1;
  localparam logic [HI_BITS-1:0] HI_EARLY = HI_TOP - HI_BITS'(1);

  logic [LO_BITS-1:0] lo_cnt;
  logic [HI_BITS-1:0] hi_cnt;
  logic               stretch;
  logic [LO_BITS-1:0] lo_last;
  logic [HI_BITS-1:0] hi_last;
  logic               lo_wrap;
  logic               hi_done;
  logic               stretch_end;

  always_comb begin
    lo_last     = stretch ? LO_HALF : LO_TOP;
    hi_last     = shorten_req ? HI_EARLY : HI_TOP;
    lo_wrap     = tick_en && (lo_cnt == lo_last);
    hi_done     = lo_wrap && !stretch && (hi_cnt == hi_last);
    stretch_end = lo_wrap && stretch;
    sec_tick    = (hi_done && !stretch_req) || stretch_end;
  end

  // Low stage: the divide-by-2^LO_BITS stage, shortened to half length while stretching.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt <= '0;
    end else if (tick_en) begin
      if (lo_wrap) lo_cnt <= '0;
      else         lo_cnt <= lo_cnt + LO_BITS'(1);
    end
  end

  // High stage: counts low-stage wraps, ends one wrap early for a fast trim.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
    end else if (lo_wrap && !stretch) begin
      if (hi_done) hi_cnt <= '0;
      else         hi_cnt <= hi_cnt + HI_BITS'(1);
    end
  end

  // Stretch phase: one extra half low-stage period appended for a slow trim.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stretch <= 1'b0;
    end else if (hi_done && stretch_req) begin
      stretch <= 1'b1;
    end else if (stretch_end) begin
      stretch <= 1'b0;
    end
  end

  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(lo_cnt) && $stable(hi_cnt) && $stable(stretch)); // R8

  AST_STRETCH_SLOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    stretch |-> stretch_req); // R4

endmodule

// File: rtl/calib_timebase.sv
module calib_timebase #(
  parameter int SEC_PER_MIN = 60,
  parameter int MIN_PER_CYC = 64,
  parameter int SEC_W = $clog2(SEC_PER_MIN),
  parameter int MIN_W = $clog2(MIN_PER_CYC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_tick,
  output logic [SEC_W-1:0] sec_pos,
  output logic [MIN_W-1:0] min_pos,
  output logic             min_tick,
  output logic             cyc_tick
);
  localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SEC_PER_MIN - 1);
  localparam logic [MIN_W-1:0] MIN_LAST = MIN_W'(MIN_PER_CYC - 1);

  always_comb begin
    min_tick = sec_tick && (sec_pos == SEC_LAST);
    cyc_tick = min_tick && (min_pos == MIN_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_pos <= '0;
    end else if (sec_tick) begin
      if (min_tick) sec_pos <= '0;
      else          sec_pos <= sec_pos + SEC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      min_pos <= '0;
    end else if (min_tick) begin
      if (cyc_tick) min_pos <= '0;
      else          min_pos <= min_pos + MIN_W'(1);
    end
  end

  AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick |=> $stable(sec_pos) && $stable(min_pos)); // R9

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && sec_pos == SEC_LAST) |=> (sec_pos == '0)); // R9

  AST_MIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (min_tick && min_pos != MIN_LAST) |=> (min_pos == $past(min_pos) + MIN_W'(1))); // R9

endmodule

// File: rtl/calib_policy.sv
module calib_policy #(
  parameter int CAL_BITS    = 5,
  parameter int MIN_PER_CYC = 64,
  parameter int SEC_W = 6,
  parameter int MIN_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CAL_BITS-1:0] cal_mag,
  input  logic                cal_fast,
  input  logic                cyc_tick,
  input  logic [SEC_W-1:0]    sec_pos,
  input  logic [MIN_W-1:0]    min_pos,
  output logic                corr_now,
  output logic                shorten_req,
  output logic                stretch_req
);
  import calib_pkg::*;

  logic [CAL_BITS-1:0] act_mag;
  trim_dir_e           act_dir;
  logic                in_window;

  // Trim in force is replaced only at the cycle boundary.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_mag <= '0;
      act_dir <= TRIM_SLOW;
    end else if (cyc_tick) begin
      act_mag <= cal_mag;
      act_dir <= cal_fast ? TRIM_FAST : TRIM_SLOW;
    end
  end

  always_comb begin
    in_window   = minute_in_window(int'(act_mag), int'(min_pos));
    corr_now    = in_window && (sec_pos == '0);
    shorten_req = corr_now && (act_dir == TRIM_FAST);
    stretch_req = corr_now && (act_dir == TRIM_SLOW);
  end

  AST_TRIM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_tick |=> $stable(act_mag) && $stable(act_dir)); // R7

  AST_LAST_MINUTES_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    corr_now |-> (int'(min_pos) <= MIN_PER_CYC - 3) && (sec_pos == '0)); // R6

endmodule

// File: rtl/calib_prescaler.sv
module calib_prescaler #(
  parameter int LO_BITS     = 8,
  parameter int HI_BITS     = 7,
  parameter int SEC_PER_MIN = 60,
  parameter int MIN_PER_CYC = 64,
  parameter int CAL_BITS    = 5,
  localparam int SEC_W = $clog2(SEC_PER_MIN),
  localparam int MIN_W = $clog2(MIN_PER_CYC)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_en,
  input  logic [CAL_BITS-1:0] cal_mag,
  input  logic                cal_fast,
  output logic                sec_tick,
  output logic                min_tick,
  output logic                cyc_tick,
  output logic [SEC_W-1:0]    sec_pos,
  output logic [MIN_W-1:0]    min_pos,
  output logic                corr_now
);
  logic shorten_req;
  logic stretch_req;

  calib_divider #(
    .LO_BITS(LO_BITS),
    .HI_BITS(HI_BITS)
  ) u_divider (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .shorten_req(shorten_req),
    .stretch_req(stretch_req),
    .sec_tick   (sec_tick)
  );

  calib_timebase #(
    .SEC_PER_MIN(SEC_PER_MIN),
    .MIN_PER_CYC(MIN_PER_CYC),
    .SEC_W      (SEC_W),
    .MIN_W      (MIN_W)
  ) u_timebase (
    .clk     (clk),
    .rst_n   (rst_n),
    .sec_tick(sec_tick),
    .sec_pos (sec_pos),
    .min_pos (min_pos),
    .min_tick(min_tick),
    .cyc_tick(cyc_tick)
  );

  calib_policy #(
    .CAL_BITS   (CAL_BITS),
    .MIN_PER_CYC(MIN_PER_CYC),
    .SEC_W      (SEC_W),
    .MIN_W      (MIN_W)
  ) u_policy (
    .clk        (clk),
    .rst_n      (rst_n),
    .cal_mag    (cal_mag),
    .cal_fast   (cal_fast),
    .cyc_tick   (cyc_tick),
    .sec_pos    (sec_pos),
    .min_pos    (min_pos),
    .corr_now   (corr_now),
    .shorten_req(shorten_req),
    .stretch_req(stretch_req)
  );

  AST_TICK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> tick_en); // R8

  AST_ONE_TRIM_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    !(shorten_req && stretch_req)); // R10

endmodule

// File: tb/test_calib_prescaler.sv
module test_calib_prescaler;
  localparam int LO = 3;
  localparam int HI = 2;
  localparam int SPM = 4;
  localparam int MPC = 64;
  localparam int CB = 5;
  localparam int NOM = 32;
  localparam int FAST_LEN = 24;
  localparam int SLOW_LEN = 36;

  // Row: [12] gapped enables, [11] fast, [10:6] magnitude, [5:0] corrected seconds per cycle.
  localparam int NROWS = 5;
  localparam logic [12:0] VEC [NROWS] = '{
    {1'b0, 1'b1, 5'd1,  6'd2},
    {1'b0, 1'b0, 5'd6,  6'd12},
    {1'b1, 1'b1, 5'd31, 6'd62},
    {1'b0, 1'b0, 5'd31, 6'd62},
    {1'b1, 1'b0, 5'd0,  6'd0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_en = 1'b0;
  logic [CB-1:0] cal_mag = '0;
  logic          cal_fast = 1'b0;
  logic          sec_tick, min_tick, cyc_tick, corr_now;
  logic [1:0]    sec_pos;
  logic [5:0]    min_pos;

  int n_chk = 0;
  int n_bad = 0;
  int en_mode = 0;
  int gcnt = 0;
  int run = 0, tot = 0, msec = 0, mmin = 0, m_mag = 0, ccnt = 0, last_ccnt = 0;
  int ncyc = 0, nticks = 0;
  logic m_fast = 1'b0;
  logic first_sec = 1'b1;

  calib_prescaler #(.LO_BITS(LO), .HI_BITS(HI), .SEC_PER_MIN(SPM),
                    .MIN_PER_CYC(MPC), .CAL_BITS(CB)) i_calib_prescaler (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cal_mag(cal_mag),
    .cal_fast(cal_fast), .sec_tick(sec_tick), .min_tick(min_tick),
    .cyc_tick(cyc_tick), .sec_pos(sec_pos), .min_pos(min_pos), .corr_now(corr_now));

  always #2.5 clk = ~clk;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Enable driver: always on, three of four, or off.
  initial forever begin
    @(posedge clk); #1;
    if (en_mode == 0)      tick_en = 1'b1;
    else if (en_mode == 1) tick_en = (gcnt % 4) != 3;
    else                   tick_en = 1'b0;
    gcnt++;
  end

  // Reference model of second lengths and positions.
  always @(negedge clk) begin
    if (!rst_n) begin
      run = 0; tot = 0; msec = 0; mmin = 0; m_mag = 0; m_fast = 1'b0;
      ccnt = 0; first_sec = 1'b1;
    end else begin
      if (sec_tick && !tick_en) chk(1'b0, "R8 tick without enable", 1, 0);
      if (tick_en) begin run++; tot++; end
      if (sec_tick) begin
        logic ec;
        int el;
        string tag;
        nticks++;
        ec = (m_mag > 0) && (msec == 0) && (mmin < 2 * m_mag);
        el = !ec ? NOM : (m_fast ? FAST_LEN : SLOW_LEN);
        if (first_sec) tag = "R1 first second after reset";
        else if (m_mag == 31 && (mmin == 61 || mmin == 62) && msec == 0) tag = "R6 window edge";
        else if (ec) tag = m_fast ? "R3 fast second" : "R4 slow second";
        else tag = "R2 nominal second";
        chk(run == el, tag, run, el);
        chk(sec_pos == msec, "R9 sec_pos", int'(sec_pos), msec);
        chk(min_pos == mmin, "R9 min_pos", int'(min_pos), mmin);
        chk(corr_now == ec, "R10 corr_now", int'(corr_now), int'(ec));
        chk(min_tick == (msec == SPM - 1), "R9 min_tick", int'(min_tick), int'(msec == SPM - 1));
        chk(cyc_tick == (msec == SPM - 1 && mmin == MPC - 1), "R9 cyc_tick",
            int'(cyc_tick), int'(msec == SPM - 1 && mmin == MPC - 1));
        if (ec) ccnt++;
        run = 0;
        first_sec = 1'b0;
        if (msec == SPM - 1) begin
          msec = 0;
          if (mmin == MPC - 1) begin
            int et;
            et = MPC * SPM * NOM + 2 * m_mag * (m_fast ? (FAST_LEN - NOM) : (SLOW_LEN - NOM));
            chk(tot == et, "R7 cycle total under trim in force", tot, et);
            mmin = 0; tot = 0;
            last_ccnt = ccnt; ccnt = 0;
            m_mag = int'(cal_mag); m_fast = cal_fast;
            ncyc++;
          end else mmin++;
        end else msec++;
      end
    end
  end

  initial begin
    int wd = 0;
    while (wd < 190000) begin @(posedge clk); wd++; end
    chk(1'b0, "watchdog expired", wd, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    cal_mag = 5'd9; cal_fast = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(sec_pos == 0 && min_pos == 0, "R1 reset positions", int'(min_pos), 0);
    chk(!sec_tick && !corr_now, "R1 reset outputs", int'(sec_tick), 0);
    @(posedge clk); #1 rst_n = 1'b1;

    // Table walk: change trim mid-cycle, then check the following full cycle.
    for (int r = 0; r < NROWS; r++) begin
      int n0;
      @(negedge clk iff (min_pos == 6'd5));
      @(posedge clk); #1;
      en_mode = VEC[r][12] ? 1 : 0;
      cal_fast = VEC[r][11];
      cal_mag = VEC[r][10:6];
      n0 = ncyc;
      wait (ncyc == n0 + 2);
      chk(last_ccnt == int'(VEC[r][5:0]), "R5 corrected seconds per cycle",
          last_ccnt, int'(VEC[r][5:0]));
    end

    // Enable held off: nothing moves.
    begin
      int t0;
      logic [1:0] s0;
      logic [5:0] m0;
      @(posedge clk); #1 en_mode = 2;
      @(negedge clk);
      t0 = nticks; s0 = sec_pos; m0 = min_pos;
      repeat (40) @(negedge clk);
      chk(nticks == t0, "R8 no tick with enable low", nticks, t0);
      chk(sec_pos == s0 && min_pos == m0, "R8 positions held", int'(sec_pos), int'(s0));
      @(posedge clk); #1 en_mode = 0;
    end

    // Mid-cycle reset with a trim applied: first cycle after release is uncorrected.
    cal_mag = 5'd5; cal_fast = 1'b1;
    wait (ncyc >= 11);
    @(negedge clk iff (min_pos == 6'd3));
    @(posedge clk); #1 rst_n = 1'b0;
    @(negedge clk);
    chk(sec_pos == 0 && min_pos == 0, "R1 positions cleared mid-run", int'(min_pos), 0);
    chk(!corr_now, "R1 corr_now cleared", int'(corr_now), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    begin
      int t1;
      t1 = nticks;
      wait (nticks == t1 + 6);
    end
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule